// File: doc/BRIEF.md
# Kernel Instance Launch Scheduler

This block decides when the next instance of a loop kernel may be dispatched onto a group of compute tiles. A run is opened with a start strobe that carries two values: the number of mapped tiles and the number of instances. The scheduler then steps through each instance. The first launch after reset is preceded by a full configuration request. Every later instance needs only a runtime-parameter bind. A launch is issued only once four things hold: configuration has finished, operands are resident in the instance's memory partition, every mapped tile is idle, and the parameters are bound.

Parameters come over a valid/ready handshake. The parameter source may hold the values for instance n+1 on its valid line while instance n is still executing. The scheduler accepts them only when the whole group is free. Each tile returns one completion token per instance. Local operand memory is split into partitions that are used in round-robin order. A partition is handed back to the fill engine, one at a time, when the instance that consumed it completes.

Top module: `inst_launch_sched`

## Requirements
- R1: A launch pulse is issued only when the block is configured, the parameters of the instance are bound, the partition for the instance is full, and no previous instance is running. It comes one cycle after the partition is seen full in the launch-wait state.
- R2: After reset, the first start with a nonzero instance count produces one cfg_req_o pulse in the cycle after start. No bind can occur until cfg_done_i has been received.
- R3: Once configured, later instances and later runs produce no cfg_req_o. They produce one bind_o pulse per instance.
- R4: The tile group becomes free only after a token on tile_done_i has arrived from every tile with index below the latched tile count. Tokens from tiles outside that range, and tokens arriving while no instance runs, have no effect.
- R5: Instance k of a run uses partition k mod NPART, counting from partition 0 after reset. A fill strobe marks a partition full, and a fill to a full partition changes nothing. The partition becomes free again in the cycle after the consuming instance's group completes. part_free_o shows the free partitions with bit i for partition i.
- R6: prm_ready_o is high only while the block waits for a bind and the group is free. bind_o pulses in the cycle after prm_valid_i and prm_ready_o are both high.
- R7: done_o rises one cycle after the group of the last instance completes. It stays high until the next accepted start clears it.
- R8: A start strobe outside the idle state is ignored.
- R9: Reset clears the configured state, so the first run after any reset performs full configuration again.
- R10: cfg_req_o, bind_o and launch_o are single-cycle pulses, and at most one of them is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Opens a run; accepted in idle only |
| tile_cnt_i | input | TCW | Number of mapped tiles, sampled at start |
| inst_cnt_i | input | IW | Number of instances, sampled at start |
| cfg_done_i | input | 1 | Configuration of tiles and orchestrator complete |
| fill_vld_i | input | 1 | Operand fill of one partition complete |
| fill_idx_i | input | PW | Partition that was filled |
| tile_done_i | input | NTILE | Per-tile completion tokens |
| prm_valid_i | input | 1 | Runtime parameters are available |
| prm_ready_o | output | 1 | Scheduler will accept parameters this cycle |
| cfg_req_o | output | 1 | Full configuration request pulse |
| bind_o | output | 1 | Parameter bind pulse |
| launch_o | output | 1 | Instance launch pulse |
| done_o | output | 1 | Last instance of the run has completed |
| part_free_o | output | NPART | Per-partition free flags |

## Verification
The bench targets several specific corner cases:
- Partial completion: a partial token set, including a token from an unmapped tile, is followed by a bind attempt. A collector that ignored the tile mask or counted tokens would free the group early and bind instance two over a running instance.
- Empty partition: a bound instance is held back by an empty partition. A scheduler that skipped the operand check would launch into stale memory.
- Configuration count: runs are repeated across a reset. A design that reconfigured every instance, or kept the configured state through reset, shows a wrong cfg_req_o count.
- Stray start: a start strobe mid-run must be ignored. Accepting it would restart the run and shift the done_o cycle.

// File: rtl/sched_pkg.sv
// Shared types for the instance launch scheduler.
// Assumes: one state machine instance per scheduler.
package sched_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CFG,
        ST_BIND,
        ST_LAUNCH,
        ST_DRAIN
    } sched_state_e;
endpackage

// File: rtl/sched_tile_sync.sv
// Collects per-tile completion tokens for the running instance.
// Assumes: arm_i pulses in the cycle an instance is launched; tile_cnt_i is
// stable while armed; tiles at index >= tile_cnt_i are not mapped.
module sched_tile_sync #(
    parameter int NTILE = 8,
    parameter int TCW   = $clog2(NTILE + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm_i,
    input  logic [TCW-1:0]   tile_cnt_i,
    input  logic [NTILE-1:0] tile_done_i,
    output logic             busy_o,
    output logic             fin_o
);
    logic [NTILE-1:0] mask;
    logic [NTILE-1:0] seen_q;
    logic             armed_q;

    // Mapped-tile mask built from the tile count.
    for (genvar g = 0; g < NTILE; g++) begin : g_mask
        assign mask[g] = (tile_cnt_i > TCW'(g));
    end

    // Group completes when every mapped tile has a token, old or new.
    assign fin_o  = armed_q && (((seen_q | tile_done_i) & mask) == mask);
    assign busy_o = armed_q;

    // Token accumulation, armed by launch, cleared on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            seen_q  <= '0;
        end else if (arm_i) begin
            armed_q <= 1'b1;
            seen_q  <= '0;
        end else if (fin_o) begin
            armed_q <= 1'b0;
            seen_q  <= '0;
        end else if (armed_q) begin
            seen_q  <= seen_q | (tile_done_i & mask);
        end
    end

    AST_NO_TOKEN_NO_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && !arm_i && (tile_done_i == '0) && (|mask) |=> busy_o); // R4
endmodule

// File: rtl/sched_part_track.sv
// Tracks which operand partitions hold unconsumed data.
// Assumes: a release targets the partition of the instance that just finished.
module sched_part_track #(
    parameter int NPART = 2,
    parameter int PW    = (NPART > 1) ? $clog2(NPART) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fill_vld_i,
    input  logic [PW-1:0]    fill_idx_i,
    input  logic             rel_vld_i,
    input  logic [PW-1:0]    rel_idx_i,
    output logic [NPART-1:0] full_o
);
    for (genvar p = 0; p < NPART; p++) begin : g_part
        // One full flag per partition; release wins over a fill.
        always_ff @(posedge clk) begin
            if (!rst_n)
                full_o[p] <= 1'b0;
            else if (rel_vld_i && rel_idx_i == PW'(p))
                full_o[p] <= 1'b0;
            else if (fill_vld_i && fill_idx_i == PW'(p))
                full_o[p] <= 1'b1;
        end
    end

    AST_FULL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !rel_vld_i |=> (($past(full_o) & ~full_o) == '0)); // R5
endmodule

// File: rtl/inst_launch_sched.sv
// Launch scheduler for instances of a loop kernel on a tile group.
// Sequences configuration (first run after reset only), parameter binds and
// launches. Partitions are consumed in round-robin order.
// Assumes: tile_cnt_i in 1..NTILE; the fill engine only fills free partitions.
module inst_launch_sched
    import sched_pkg::*;
#(
    parameter int NTILE = 8,
    parameter int NPART = 2,
    parameter int IW    = 8,
    parameter int TCW   = $clog2(NTILE + 1),
    parameter int PW    = (NPART > 1) ? $clog2(NPART) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [TCW-1:0]   tile_cnt_i,
    input  logic [IW-1:0]    inst_cnt_i,
    input  logic             cfg_done_i,
    input  logic             fill_vld_i,
    input  logic [PW-1:0]    fill_idx_i,
    input  logic [NTILE-1:0] tile_done_i,
    input  logic             prm_valid_i,
    output logic             prm_ready_o,
    output logic             cfg_req_o,
    output logic             bind_o,
    output logic             launch_o,
    output logic             done_o,
    output logic [NPART-1:0] part_free_o
);
    sched_state_e     state_q;
    logic             cfg_q;
    logic [TCW-1:0]   tcnt_q;
    logic [IW-1:0]    remain_q;
    logic [PW-1:0]    cur_q;
    logic [PW-1:0]    run_q;
    logic             grp_busy;
    logic             grp_fin;
    logic             fire;
    logic [NPART-1:0] part_full;

    // A launch fires when the bound instance finds its partition full.
    assign fire        = (state_q == ST_LAUNCH) && part_full[cur_q];
    assign prm_ready_o = (state_q == ST_BIND) && !grp_busy;
    assign part_free_o = ~part_full;

    sched_tile_sync #(.NTILE(NTILE), .TCW(TCW)) u_sync (
        .clk(clk), .rst_n(rst_n), .arm_i(fire), .tile_cnt_i(tcnt_q),
        .tile_done_i(tile_done_i), .busy_o(grp_busy), .fin_o(grp_fin)
    );

    sched_part_track #(.NPART(NPART), .PW(PW)) u_part (
        .clk(clk), .rst_n(rst_n), .fill_vld_i(fill_vld_i),
        .fill_idx_i(fill_idx_i), .rel_vld_i(grp_fin), .rel_idx_i(run_q),
        .full_o(part_full)
    );

    // Main sequencer: configure once, then bind and launch per instance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            cfg_q     <= 1'b0;
            tcnt_q    <= '0;
            remain_q  <= '0;
            cur_q     <= '0;
            run_q     <= '0;
            cfg_req_o <= 1'b0;
            bind_o    <= 1'b0;
            launch_o  <= 1'b0;
            done_o    <= 1'b0;
        end else begin
            cfg_req_o <= 1'b0;
            bind_o    <= 1'b0;
            launch_o  <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (start_i) begin
                    tcnt_q   <= tile_cnt_i;
                    remain_q <= inst_cnt_i;
                    done_o   <= 1'b0;
                    if (inst_cnt_i == '0) begin
                        state_q <= ST_DRAIN;
                    end else if (cfg_q) begin
                        state_q <= ST_BIND;
                    end else begin
                        state_q   <= ST_CFG;
                        cfg_req_o <= 1'b1;
                    end
                end
                ST_CFG: if (cfg_done_i) begin
                    cfg_q   <= 1'b1;
                    state_q <= ST_BIND;
                end
                ST_BIND: if (prm_valid_i && prm_ready_o) begin
                    bind_o  <= 1'b1;
                    state_q <= ST_LAUNCH;
                end
                ST_LAUNCH: if (fire) begin
                    launch_o <= 1'b1;
                    run_q    <= cur_q;
                    cur_q    <= (cur_q == PW'(NPART - 1)) ? '0 : cur_q + 1'b1;
                    remain_q <= remain_q - 1'b1;
                    state_q  <= (remain_q == IW'(1)) ? ST_DRAIN : ST_BIND;
                end
                ST_DRAIN: if (!grp_busy) begin
                    done_o  <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    AST_LAUNCH_GROUP_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        launch_o |-> $past(!grp_busy)); // R1
    AST_LAUNCH_CONFIGURED: assert property (@(posedge clk) disable iff (!rst_n)
        launch_o |-> cfg_q); // R1
    AST_CFG_ONLY_UNCONFIGURED: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req_o |-> !cfg_q); // R3
    AST_BIND_AFTER_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        bind_o |-> $past(prm_valid_i)); // R6
    AST_DONE_GROUP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !grp_busy); // R7
    AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cfg_req_o, bind_o, launch_o})); // R10
    AST_BIND_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        bind_o |=> !bind_o); // R10
endmodule

// File: tb/sim_inst_launch_sched.sv
module sim_inst_launch_sched;
    localparam int NTILE = 8;
    localparam int NPART = 2;
    localparam int IW    = 8;
    localparam int TCW   = $clog2(NTILE + 1);
    localparam int PW    = 1;

    // Rows: {tile count[3:0], instance count[7:0], expected cfg requests[3:0]}
    localparam logic [15:0] TBL [4] = '{
        {4'd4, 8'd3, 4'd1},
        {4'd8, 8'd2, 4'd0},
        {4'd1, 8'd5, 4'd0},
        {4'd2, 8'd1, 4'd0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [TCW-1:0] tile_cnt_i = '0;
    logic [IW-1:0] inst_cnt_i = '0;
    logic cfg_done_i = 1'b0;
    logic fill_vld_i = 1'b0;
    logic [PW-1:0] fill_idx_i = '0;
    logic [NTILE-1:0] tile_done_i = '0;
    logic prm_valid_i = 1'b0;
    logic prm_ready_o, cfg_req_o, bind_o, launch_o, done_o;
    logic [NPART-1:0] part_free_o;

    int total = 0;
    int failed = 0;
    int n_cfg = 0, n_bind = 0, n_launch = 0;

    always #10 clk = ~clk;

    inst_launch_sched #(.NTILE(NTILE), .NPART(NPART), .IW(IW)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .tile_cnt_i(tile_cnt_i),
        .inst_cnt_i(inst_cnt_i), .cfg_done_i(cfg_done_i), .fill_vld_i(fill_vld_i),
        .fill_idx_i(fill_idx_i), .tile_done_i(tile_done_i), .prm_valid_i(prm_valid_i),
        .prm_ready_o(prm_ready_o), .cfg_req_o(cfg_req_o), .bind_o(bind_o),
        .launch_o(launch_o), .done_o(done_o), .part_free_o(part_free_o)
    );

    // Pulse counters sampled mid-cycle.
    always @(negedge clk) begin
        if (rst_n) begin
            if (cfg_req_o) n_cfg++;
            if (bind_o)    n_bind++;
            if (launch_o)  n_launch++;
        end
    end

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset;
        rst_n = 1'b0;
        tick;
        tick;
        rst_n = 1'b1;
    endtask

    // Reactive environment for one complete run.
    task automatic run_kernel(input int tc, input int ni, input int exp_cfg, input int row);
        int c0 = n_cfg, b0 = n_bind, l0 = n_launch;
        int cnt = -1;
        start_i = 1'b1;
        tile_cnt_i = TCW'(tc);
        inst_cnt_i = IW'(ni);
        prm_valid_i = 1'b1;
        tick;
        start_i = 1'b0;
        for (int c = 0; c < 2000; c++) begin
            cfg_done_i  = cfg_req_o;
            tile_done_i = '0;
            if (launch_o) cnt = 3;
            else if (cnt > 0) cnt--;
            if (cnt == 0) begin
                tile_done_i = '1;
                cnt = -1;
            end
            fill_vld_i = |part_free_o;
            fill_idx_i = part_free_o[0] ? 1'b0 : 1'b1;
            tick;
            if (done_o) break;
        end
        cfg_done_i = 1'b0; fill_vld_i = 1'b0; tile_done_i = '0; prm_valid_i = 1'b0;
        chk($sformatf("R2 R3 row%0d cfg requests", row), n_cfg - c0, exp_cfg);
        chk($sformatf("R3 row%0d binds", row), n_bind - b0, ni);
        chk($sformatf("R1 row%0d launches", row), n_launch - l0, ni);
        chk($sformatf("R7 row%0d done", row), int'(done_o), 1);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        total++;
        failed++;
        $display("FAIL watchdog: actual hang expected completion");
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

    initial begin
        do_reset;
        // Reset state
        chk("R9 reset cfg_req", int'(cfg_req_o), 0);
        chk("R9 reset bind/launch", int'(bind_o | launch_o), 0);
        chk("R9 reset prm_ready", int'(prm_ready_o), 0);
        chk("R9 reset done", int'(done_o), 0);
        chk("R5 reset partitions free", int'(part_free_o), 3);

        // Table of runs
        for (int r = 0; r < 4; r++)
            run_kernel(int'(TBL[r][15:12]), int'(TBL[r][11:4]), int'(TBL[r][3:0]), r);

        // Reset clears configured; partial tokens hold the group
        do_reset;
        fill_vld_i = 1'b1; fill_idx_i = 1'b0; tick;
        fill_idx_i = 1'b1; tick;
        fill_vld_i = 1'b0;
        chk("R5 both partitions full", int'(part_free_o), 0);
        start_i = 1'b1; tile_cnt_i = TCW'(3); inst_cnt_i = IW'(2); tick;
        start_i = 1'b0;
        chk("R9 R2 cfg_req after reset", int'(cfg_req_o), 1);
        tick;
        chk("R10 cfg_req single", int'(cfg_req_o), 0);
        tick;
        chk("R2 no ready before cfg_done", int'(prm_ready_o), 0);
        cfg_done_i = 1'b1; tick;
        cfg_done_i = 1'b0;
        chk("R6 ready in bind wait", int'(prm_ready_o), 1);
        tick; tick;
        chk("R6 no bind without valid", int'(bind_o), 0);
        prm_valid_i = 1'b1; tick;
        chk("R6 bind pulse", int'(bind_o), 1);
        tick;
        chk("R1 launch on full partition", int'(launch_o), 1);
        chk("R10 bind dropped", int'(bind_o), 0);
        chk("R4 not ready while running", int'(prm_ready_o), 0);
        tile_done_i = 8'b0010_0011; tick;
        tile_done_i = '0; tick;
        chk("R4 partial tokens keep group busy", int'(prm_ready_o), 0);
        chk("R4 no early bind", int'(bind_o), 0);
        chk("R5 partition held while running", int'(part_free_o), 0);
        tile_done_i = 8'b0000_0100; tick;
        tile_done_i = '0;
        chk("R5 partition 0 released", int'(part_free_o), 1);
        chk("R4 group free after all tokens", int'(prm_ready_o), 1);
        tick;
        chk("R3 second bind", int'(bind_o), 1);
        chk("R3 no reconfiguration", int'(cfg_req_o), 0);
        prm_valid_i = 1'b0; tick;
        chk("R5 launch from partition 1", int'(launch_o), 1);
        chk("R7 done low while last runs", int'(done_o), 0);
        tile_done_i = 8'b0000_0111; tick;
        tile_done_i = '0;
        chk("R7 done not yet", int'(done_o), 0);
        chk("R5 all partitions free", int'(part_free_o), 3);
        tick;
        chk("R7 done after last completion", int'(done_o), 1);

        // Empty partition stalls launch; stray start ignored
        start_i = 1'b1; tile_cnt_i = TCW'(1); inst_cnt_i = IW'(1); tick;
        start_i = 1'b0;
        chk("R3 configured run no cfg_req", int'(cfg_req_o), 0);
        chk("R7 done cleared by start", int'(done_o), 0);
        prm_valid_i = 1'b1; tick;
        prm_valid_i = 1'b0;
        chk("R6 bind third run", int'(bind_o), 1);
        for (int i = 0; i < 3; i++) begin
            tick;
            chk("R1 no launch with empty partition", int'(launch_o), 0);
        end
        fill_vld_i = 1'b1; fill_idx_i = 1'b0; tick;
        fill_vld_i = 1'b0;
        chk("R1 launch waits for fill", int'(launch_o), 0);
        tick;
        chk("R1 launch after fill", int'(launch_o), 1);
        start_i = 1'b1; inst_cnt_i = IW'(5); tick;
        start_i = 1'b0; tick;
        chk("R8 stray start no bind", int'(bind_o | cfg_req_o), 0);
        chk("R8 stray start no done", int'(done_o), 0);
        tile_done_i = 8'b0000_0001; tick;
        tile_done_i = '0; tick;
        chk("R8 run ends as started", int'(done_o), 1);

        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end
endmodule